// File: doc/BRIEF.md
# 256-bit-Key ARX Block Cipher Engine

This block encrypts a single 128-bit block under a 256-bit key. It uses an add-rotate-xor cipher with 32 rounds and runs one full round per clock. A start strobe captures the key and the plaintext. The engine then iterates by itself. A one-cycle done flag marks the moment the ciphertext is ready. The ciphertext stays on its output until the next accepted start.

The key schedule keeps eight 32-bit key words in a register file. Each round rewrites six of them. The file shifts by two positions every round, so the six words due for update always sit in the same six physical registers. As a result the update lanes are fixed wires and need no selection logic. A ring of eight constant registers supplies the key-schedule constants. The ring advances by one position and one bit of left rotation per round. The four-word data state passes through a three-adder mixing step.

Top module: `arx256_encrypt`

## Requirements
- R1: While reset is held and after its release, with no start, `done` is 0 and `ctext` is all zeros.
- R2: Words are little-endian within the buses: key word Kn is `key[32n+31:32n]` for n = 0..7, plaintext word Pn is `ptext[32n+31:32n]`, and ciphertext word Cn is `ctext[32n+31:32n]`. The state starts as Xn = Pn, and C is the state after 32 rounds.
- R3: The key state starts as Tn = Kn. In round i (0..31), for j = 0..5 in order, the word T[(6i+j) mod 8] is replaced by rotl(T[(6i+j) mod 8] + rotl(D[i mod 8], i+j), s_j), where s = 1, 3, 6, 11, 13, 17. The six new words, in j order, are round keys RK0..RK5.
- R4: A round maps X to X0' = rotl((X0^RK0)+(X1^RK1), 9), X1' = rotr((X1^RK2)+(X2^RK3), 5), X2' = rotr((X2^RK4)+(X3^RK5), 3), X3' = X0. All additions are modulo 2^32.
- R5: A start sampled while idle is accepted. `done` goes high exactly 32 clock edges after the accepting edge, for exactly one cycle.
- R6: After `done`, `ctext` holds the ciphertext unchanged until the next accepted start.
- R7: A start raised while an encryption is running is ignored. The running block completes on its original schedule with its original result.
- R8: A start raised in the same cycle as `done` is accepted, so blocks run back to back with no idle cycle.
- R9: The constants D0..D7 are C3EFE9DB, 44626B02, 79E27C8A, 78DF30EC, 715EA49E, C785DA0A, E04EF22A and E5C40957 (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an encryption when idle |
| key | input | 256 | Key, word n in bits 32n+31:32n |
| ptext | input | 128 | Plaintext, word n in bits 32n+31:32n |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ctext | output | 128 | Ciphertext, valid from done until next start |

## Verification
Each round key feeds the data state in the same cycle. Because of this, a single wrong key word, a constant sitting at the wrong ring position, or a misrouted shift of the key file scrambles the whole ciphertext at the `done` pulse, 32 cycles after start. A miscounted round counter shows up as `done` arriving early or late, or more than once. A key-only or constant-only fault is still exposed by an all-zero key and plaintext, since the constants alone then drive the result. Start handling is observed through the timing of `done` and through whether `ctext` holds steady afterwards.

// File: rtl/arx256_pkg.sv
package arx256_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned KEY_WORDS = 8;
   localparam int unsigned RK_WORDS  = 6;
   localparam int unsigned BLK_WORDS = 4;

   typedef logic [WORD_W-1:0] word_t;

   function automatic word_t rotl(input word_t v, input int unsigned n);
      int unsigned s;
      s = n % WORD_W;
      return (s == 0) ? v : ((v << s) | (v >> (WORD_W - s)));
   endfunction

   // key-schedule seed constants, index taken modulo 8
   function automatic word_t seed_const(input int unsigned k);
      case (k % 8)
         0:       return 32'hC3EFE9DB;
         1:       return 32'h44626B02;
         2:       return 32'h79E27C8A;
         3:       return 32'h78DF30EC;
         4:       return 32'h715EA49E;
         5:       return 32'hC785DA0A;
         6:       return 32'hE04EF22A;
         default: return 32'hE5C40957;
      endcase
   endfunction

   // left rotation applied to each key-update lane
   function automatic int unsigned lane_rot(input int unsigned j);
      case (j)
         0:       return 1;
         1:       return 3;
         2:       return 6;
         3:       return 11;
         4:       return 13;
         default: return 17;
      endcase
   endfunction

   // mixing rotations expressed as left amounts: left 9, right 5, right 3
   function automatic int unsigned mix_rot(input int unsigned m);
      case (m)
         0:       return 9;
         1:       return WORD_W - 5;
         default: return WORD_W - 3;
      endcase
   endfunction
endpackage

// File: rtl/arx256_const_ring.sv
module arx256_const_ring
   import arx256_pkg::*;
#(
   parameter int unsigned DEPTH = KEY_WORDS,
   parameter int unsigned TAPS  = RK_WORDS
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         step,
   output logic [TAPS-1:0][WORD_W-1:0]  taps
);
   word_t ring [DEPTH];

   if (TAPS > WORD_W) begin : g_bad_taps
      $error("const ring: TAPS must not exceed the word width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) ring[k] <= seed_const(k);
      end else if (load) begin
         for (int k = 0; k < DEPTH; k++) ring[k] <= seed_const(k);
      end else if (step) begin
         for (int k = 0; k < DEPTH; k++) ring[k] <= rotl(ring[(k + 1) % DEPTH], 1);
      end
   end

   // head holds the round's base constant; lane j needs j more bits of rotation
   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      assign taps[j] = rotl(ring[0], j);
   end
endmodule

// File: rtl/arx256_key_file.sv
module arx256_key_file
   import arx256_pkg::*;
#(
   parameter int unsigned DEPTH = KEY_WORDS,
   parameter int unsigned LANES = RK_WORDS
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic                          step,
   input  logic [DEPTH*WORD_W-1:0]       key_in,
   input  logic [LANES-1:0][WORD_W-1:0]  ctaps,
   output logic [LANES-1:0][WORD_W-1:0]  rk
);
   localparam int unsigned SHIFT = DEPTH - LANES;

   if (LANES >= DEPTH) begin : g_bad_lanes
      $error("key file: LANES must be smaller than DEPTH");
   end

   word_t t   [DEPTH];
   word_t upd [LANES];

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign upd[j] = rotl(t[j] + ctaps[j], lane_rot(j));
      assign rk[j]  = upd[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) t[k] <= '0;
      end else if (load) begin
         for (int k = 0; k < DEPTH; k++) t[k] <= key_in[k*WORD_W +: WORD_W];
      end else if (step) begin
         for (int k = 0; k < LANES; k++)      t[k + SHIFT] <= upd[k];
         for (int k = LANES; k < DEPTH; k++)  t[k - LANES] <= t[k];
      end
   end
endmodule

// File: rtl/arx256_round.sv
module arx256_round
   import arx256_pkg::*;
(
   input  logic [BLK_WORDS-1:0][WORD_W-1:0] x,
   input  logic [RK_WORDS-1:0][WORD_W-1:0]  rk,
   output logic [BLK_WORDS-1:0][WORD_W-1:0] nx
);
   for (genvar m = 0; m < BLK_WORDS - 1; m++) begin : g_mix
      assign nx[m] = rotl((x[m] ^ rk[2*m]) + (x[m+1] ^ rk[2*m+1]), mix_rot(m));
   end
   assign nx[BLK_WORDS-1] = x[0];
endmodule

// File: rtl/arx256_encrypt.sv
module arx256_encrypt
   import arx256_pkg::*;
#(
   parameter int unsigned ROUNDS = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [255:0] key,
   input  logic [127:0] ptext,
   output logic         done,
   output logic [127:0] ctext
);
   localparam int unsigned CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

   if (ROUNDS < 1 || ROUNDS > 65536) begin : g_bad_rounds
      $error("arx256_encrypt: ROUNDS out of range");
   end
   if (KEY_WORDS * WORD_W != 256 || BLK_WORDS * WORD_W != 128) begin : g_bad_width
      $error("arx256_encrypt: port widths do not match package sizes");
   end

   logic                              busy;
   logic [CW-1:0]                     rnd;
   logic                              done_q;
   logic [BLK_WORDS-1:0][WORD_W-1:0]  x_q;
   logic [BLK_WORDS-1:0][WORD_W-1:0]  x_nx;
   logic [RK_WORDS-1:0][WORD_W-1:0]   ctaps;
   logic [RK_WORDS-1:0][WORD_W-1:0]   rk;

   logic accept, last;
   assign accept = start && !busy;
   assign last   = busy && (rnd == CW'(ROUNDS - 1));

   arx256_const_ring #(.DEPTH(KEY_WORDS), .TAPS(RK_WORDS)) u_ring (
      .clk (clk), .rst_n (rst_n), .load (accept), .step (busy), .taps (ctaps)
   );

   arx256_key_file #(.DEPTH(KEY_WORDS), .LANES(RK_WORDS)) u_keys (
      .clk (clk), .rst_n (rst_n), .load (accept), .step (busy),
      .key_in (key), .ctaps (ctaps), .rk (rk)
   );

   arx256_round u_round (.x (x_q), .rk (rk), .nx (x_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rnd    <= '0;
         done_q <= 1'b0;
         x_q    <= '0;
      end else begin
         done_q <= last;
         if (accept) begin
            busy <= 1'b1;
            rnd  <= '0;
            x_q  <= ptext;
         end else if (busy) begin
            x_q <= x_nx;
            rnd <= rnd + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end

   assign done  = done_q;
   assign ctext = x_q;
endmodule

// File: rtl/arx256_checker.sv
module arx256_checker #(
   parameter int unsigned ROUNDS = 32,
   parameter int unsigned CW     = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          done,
   input logic [127:0]  ctext,
   input logic          busy,
   input logic [CW-1:0] rnd
);
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rnd == CW'(ROUNDS - 1)) |=> (done && !busy));

   assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && rnd == '0));

   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && rnd != CW'(ROUNDS - 1)) |=> (busy && rnd == CW'($past(rnd) + 1)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(ctext));

   assert_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (busy && rnd == '0));
endmodule

bind arx256_encrypt arx256_checker #(.ROUNDS(ROUNDS), .CW(CW)) u_chk (
   .clk (clk), .rst_n (rst_n), .start (start), .done (done),
   .ctext (ctext), .busy (busy), .rnd (rnd)
);

// File: tb/arx256_encrypt_test.sv
module arx256_encrypt_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [255:0] key = '0;
   logic [127:0] ptext = '0;
   logic         done;
   logic [127:0] ctext;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   arx256_encrypt uut (
      .clk (clk), .rst_n (rst_n), .start (start), .key (key),
      .ptext (ptext), .done (done), .ctext (ctext)
   );

   function automatic logic [31:0] rl(input logic [31:0] v, input int n);
      int s;
      s = n % 32;
      if (s == 0) return v;
      return (v << s) | (v >> (32 - s));
   endfunction

   function automatic logic [31:0] dconst(input int k);
      case (k)
         0: return 32'hC3EFE9DB;  1: return 32'h44626B02;
         2: return 32'h79E27C8A;  3: return 32'h78DF30EC;
         4: return 32'h715EA49E;  5: return 32'hC785DA0A;
         6: return 32'hE04EF22A;  default: return 32'hE5C40957;
      endcase
   endfunction

   // behavioural reference: key words indexed modulo 8, no physical rotation
   function automatic logic [127:0] model(input logic [255:0] k, input logic [127:0] p);
      logic [31:0] T [8];
      logic [31:0] X [4];
      logic [31:0] R [6];
      logic [31:0] x0;
      int          sh [6];
      logic [127:0] c;
      sh[0] = 1; sh[1] = 3; sh[2] = 6; sh[3] = 11; sh[4] = 13; sh[5] = 17;
      for (int n = 0; n < 8; n++) T[n] = k[32*n +: 32];
      for (int n = 0; n < 4; n++) X[n] = p[32*n +: 32];
      for (int i = 0; i < 32; i++) begin
         for (int j = 0; j < 6; j++) begin
            int idx;
            idx = (6*i + j) % 8;
            T[idx] = rl(T[idx] + rl(dconst(i % 8), i + j), sh[j]);
            R[j] = T[idx];
         end
         x0   = X[0];
         X[0] = rl((X[0] ^ R[0]) + (X[1] ^ R[1]), 9);
         X[1] = rl((X[1] ^ R[2]) + (X[2] ^ R[3]), 27);
         X[2] = rl((X[2] ^ R[4]) + (X[3] ^ R[5]), 29);
         X[3] = x0;
      end
      for (int n = 0; n < 4; n++) c[32*n +: 32] = X[n];
      return c;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // start at a negedge (or right now if now=1), then count edges until done
   task automatic run(input logic [255:0] k, input logic [127:0] p, input bit now,
                      output logic [127:0] c, output int lat);
      if (!now) @(negedge clk);
      key = k; ptext = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      c = ctext;
   endtask

   function automatic logic [255:0] rand_key();
      logic [255:0] v;
      for (int n = 0; n < 8; n++) v[32*n +: 32] = $urandom();
      return v;
   endfunction

   function automatic logic [127:0] rand_blk();
      logic [127:0] v;
      for (int n = 0; n < 4; n++) v[32*n +: 32] = $urandom();
      return v;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R5: watchdog expired, actual hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [127:0] c, ca, cb;
      logic [255:0] ka, kb;
      logic [127:0] pa, pb;
      int lat, seed;
      seed = $urandom(32'd4242);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 done in reset", {127'd0, done}, 128'd0);
      chk("R1 ctext in reset", ctext, 128'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 done after reset", {127'd0, done}, 128'd0);
      chk("R1 ctext after reset", ctext, 128'd0);

      // R9: all-zero key and block, constants alone shape the result
      run('0, '0, 1'b0, c, lat);
      chk("R9 zero key/block", c, model('0, '0));
      chk("R5 latency", 128'(lat), 128'd32);
      @(negedge clk);
      chk("R5 single-cycle done", {127'd0, done}, 128'd0);

      // R3: all-ones and single-bit keys stress the modulo-8 word rotation
      run('1, '1, 1'b0, c, lat);
      chk("R3 all-ones", c, model('1, '1));
      run(256'd1 << 255, 128'd0, 1'b0, c, lat);
      chk("R3 top key bit", c, model(256'd1 << 255, 128'd0));
      run(256'd1 << 224, 128'd1, 1'b0, c, lat);
      chk("R3 key word 7", c, model(256'd1 << 224, 128'd1));

      // R2/R4: byte-ramp plaintext to pin word order
      ka = 256'h1f1e1d1c1b1a191817161514131211100f0e0d0c0b0a09080706050403020100;
      pa = 128'h3f3e3d3c3b3a39383736353433323130;
      run(ka, pa, 1'b0, c, lat);
      chk("R2 word order", c, model(ka, pa));
      run('0, 128'h80000000_00000000_00000000_00000001, 1'b0, c, lat);
      chk("R4 plaintext edge bits", c, model('0, 128'h80000000_00000000_00000000_00000001));

      // R2/R3/R4: random blocks
      for (int n = 0; n < 16; n++) begin
         ka = rand_key();
         pa = rand_blk();
         run(ka, pa, 1'b0, c, lat);
         chk("R2 random", c, model(ka, pa));
         chk("R5 random latency", 128'(lat), 128'd32);
      end

      // R6: result holds while idle
      repeat (7) @(negedge clk);
      chk("R6 hold", ctext, model(ka, pa));

      // R7: start while busy is ignored
      ka = rand_key(); pa = rand_blk();
      kb = rand_key(); pb = rand_blk();
      @(negedge clk);
      key = ka; ptext = pa; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
         if (lat == 10) begin key = kb; ptext = pb; start = 1'b1; end
         if (lat == 11) start = 1'b0;
      end
      chk("R7 busy start latency", 128'(lat), 128'd32);
      chk("R7 busy start result", ctext, model(ka, pa));
      repeat (3) @(negedge clk);
      chk("R7 no second run", {127'd0, done}, 128'd0);
      chk("R6 hold after ignored start", ctext, model(ka, pa));

      // R8: back-to-back start in the done cycle
      run(ka, pa, 1'b0, ca, lat);
      chk("R8 first block", ca, model(ka, pa));
      run(kb, pb, 1'b1, cb, lat);
      chk("R8 second block", cb, model(kb, pb));
      chk("R8 back-to-back latency", 128'(lat), 128'd32);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule